// File: doc/BRIEF.md
# Sequential Big-Integer Multiplier with Squaring Shortcut

This block multiplies two wide unsigned numbers that are stored as arrays of fixed-width limbs. It owns exactly one limb-by-limb multiplier and steps it through the limb pairs, one pair per clock. Each limb product is added into a double-width accumulator at the limb position given by the sum of the two limb indices. Both operands are presented in full on parallel ports. A one-cycle `start` request loads them together with a mode bit, and the result is read from the accumulator once the `done` pulse appears.

In square mode only operand A is used. Because the product of limbs i and j is the same as the product of limbs j and i, the block walks only the pairs with j not below i. It adds each diagonal product once and each off-diagonal product doubled by a one-bit left shift. With the default of 11 limbs of 64 bits, a square takes 66 limb products where a general multiply takes 121. The limb width and the limb count are parameters.

Top module: `bigmul_top`

## Requirements
- R1: In general mode (`mode`=0) the result after `done` equals op_a times op_b, exact over the full 2·NUM_LIMBS·LIMB_W bits.
- R2: In square mode (`mode`=1) the result after `done` equals op_a times op_a, and the value on op_b has no effect on it.
- R3: The accumulator carries one extra limb of headroom above the result, and that limb stays zero at all times, including for all-ones operands.
- R4: In general mode `done` rises on the (NUM_LIMBS²+1)-th rising edge after the edge that accepts `start`, and on none before it.
- R5: In square mode `done` rises on the (NUM_LIMBS·(NUM_LIMBS+1)/2+1)-th rising edge after the edge that accepts `start`, and on none before it.
- R6: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and low at all other times. `done` lasts exactly one cycle and is never high together with `busy`.
- R7: A `start` that arrives while `busy` is high is ignored. The operation in progress finishes with its original operands and mode.
- R8: While `busy` is low and no `start` is given, `result` holds its value.
- R9: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an operation; accepted only while idle |
| mode | input | 1 | 0 = general multiply, 1 = square of op_a |
| op_a | input | NUM_LIMBS·LIMB_W | Operand A, limb 0 in the least significant bits |
| op_b | input | NUM_LIMBS·LIMB_W | Operand B, unused in square mode |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when the result is complete |
| result | output | 2·NUM_LIMBS·LIMB_W | Product, valid from the `done` pulse until the next accepted start |

## Verification
`busy` is due one edge after the accepting edge. `done` and the final `result` are due NUM_LIMBS²+1 edges after it in general mode and NUM_LIMBS·(NUM_LIMBS+1)/2+1 edges after it in square mode. The bench drives inputs on falling edges and counts falling edges from the start pulse. It reads `done` one edge early, expecting it low, then exactly on the due edge, expecting it high together with the product, then one edge later, expecting the pulse to be over. A few more idle edges confirm that the result holds.

// File: rtl/bigmul_pkg.sv
// Package bigmul_pkg
// Shared types for the sequential big-integer multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bigmul_pkg;

    // Operation selected at start
    typedef enum logic {
        OP_GENERAL = 1'b0,
        OP_SQUARE  = 1'b1
    } bigmul_op_e;

    // Sequencer state
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_DRAIN = 2'd2
    } bigmul_state_e;

endpackage

// File: rtl/bigmul_seq.sv
// Module bigmul_seq
// Walks the limb index pairs (i outer, j inner), issuing one pair per cycle.
// General mode visits every j; square mode starts j at i. After the last
// issue it waits one drain cycle for the accumulator stage, then pulses done.
// Assumes NUM_LIMBS >= 2 and that accept is only asserted while idle.
module bigmul_seq
    import bigmul_pkg::*;
#(
    parameter int NUM_LIMBS = 11,
    localparam int IDX_W = (NUM_LIMBS > 1) ? $clog2(NUM_LIMBS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  bigmul_op_e       op,
    output logic             issue,
    output logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] idx_j,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LIMBS - 1);

    bigmul_state_e state;
    logic          last_pair;

    // Final pair of the walk is (N-1, N-1) in both modes
    assign last_pair = (idx_i == LAST_IDX) && (idx_j == LAST_IDX);
    assign issue     = (state == SQ_ISSUE);
    assign busy      = (state != SQ_IDLE);

    // State, index counters and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            idx_i <= '0;
            idx_j <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        state <= SQ_ISSUE;
                        idx_i <= '0;
                        idx_j <= '0;
                    end
                end
                SQ_ISSUE: begin
                    if (last_pair) begin
                        state <= SQ_DRAIN;
                    end else if (idx_j == LAST_IDX) begin
                        idx_i <= idx_i + 1'b1;
                        idx_j <= (op == OP_SQUARE) ? idx_i + 1'b1 : '0;
                    end else begin
                        idx_j <= idx_j + 1'b1;
                    end
                end
                SQ_DRAIN: begin
                    state <= SQ_IDLE;
                    done  <= 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bigmul_mac.sv
// Module bigmul_mac
// One limb multiplier followed by a registered product stage and a
// full-width accumulator. A product is optionally doubled, then added
// at limb offset off_limb. Carries resolve inside the same wide add.
// Assumes clear never coincides with a valid staged product.
module bigmul_mac #(
    parameter int LIMB_W    = 64,
    parameter int NUM_LIMBS = 11,
    localparam int PROD_W = 2 * LIMB_W + 1,
    localparam int ACC_W  = (2 * NUM_LIMBS + 1) * LIMB_W,
    localparam int OFF_W  = $clog2(2 * NUM_LIMBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              issue,
    input  logic [LIMB_W-1:0] limb_x,
    input  logic [LIMB_W-1:0] limb_y,
    input  logic              dbl,
    input  logic [OFF_W-1:0]  off_limb,
    output logic [ACC_W-1:0]  acc
);

    logic [2*LIMB_W-1:0] prod;
    logic [PROD_W-1:0]   prod_adj;
    logic                st_valid;
    logic [PROD_W-1:0]   st_val;
    logic [OFF_W-1:0]    st_off;
    logic [ACC_W-1:0]    st_aligned;

    // Single limb multiply, doubled for mirrored off-diagonal pairs
    always_comb begin
        prod     = (2 * LIMB_W)'(limb_x) * (2 * LIMB_W)'(limb_y);
        prod_adj = dbl ? {prod, 1'b0} : {1'b0, prod};
    end

    // Align the staged product to its limb offset
    always_comb begin
        st_aligned = ACC_W'(st_val) << (int'(st_off) * LIMB_W);
    end

    // Product stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_val   <= '0;
            st_off   <= '0;
        end else begin
            st_valid <= issue;
            if (issue) begin
                st_val <= prod_adj;
                st_off <= off_limb;
            end
        end
    end

    // Accumulator: cleared on accept, summed on every staged product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (st_valid) begin
            acc <= acc + st_aligned;
        end
    end

endmodule

// File: rtl/bigmul_top.sv
// Module bigmul_top
// Sequential multiplier of two NUM_LIMBS x LIMB_W unsigned operands with a
// squaring mode that visits only the upper triangle of limb pairs.
// Operands and mode are latched on an accepted start; start is ignored
// while busy. The result is the low 2*NUM_LIMBS limbs of the accumulator.
module bigmul_top
    import bigmul_pkg::*;
#(
    parameter int LIMB_W    = 64,
    parameter int NUM_LIMBS = 11,
    localparam int OP_W  = NUM_LIMBS * LIMB_W,
    localparam int RES_W = 2 * OP_W,
    localparam int ACC_W = RES_W + LIMB_W,
    localparam int IDX_W = (NUM_LIMBS > 1) ? $clog2(NUM_LIMBS) : 1,
    localparam int OFF_W = $clog2(2 * NUM_LIMBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);

    logic              accept;
    logic [OP_W-1:0]   a_q;
    logic [OP_W-1:0]   b_q;
    bigmul_op_e        op_q;
    logic              issue;
    logic [IDX_W-1:0]  idx_i;
    logic [IDX_W-1:0]  idx_j;
    logic [LIMB_W-1:0] a_limb [NUM_LIMBS];
    logic [LIMB_W-1:0] b_limb [NUM_LIMBS];
    logic [LIMB_W-1:0] limb_x;
    logic [LIMB_W-1:0] limb_y;
    logic              dbl;
    logic [OFF_W-1:0]  off_limb;
    logic [ACC_W-1:0]  acc;
    logic [LIMB_W-1:0] acc_head;

    // A request is taken only when no operation is running
    assign accept = start && !busy;

    // Latch operands and mode on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= OP_GENERAL;
        end else if (accept) begin
            a_q  <= op_a;
            b_q  <= op_b;
            op_q <= bigmul_op_e'(mode);
        end
    end

    // Split the latched operands into limb arrays
    for (genvar g = 0; g < NUM_LIMBS; g++) begin : g_limb
        assign a_limb[g] = a_q[g*LIMB_W +: LIMB_W];
        assign b_limb[g] = b_q[g*LIMB_W +: LIMB_W];
    end

    // Pick the limb pair; square mode takes both factors from A
    always_comb begin
        limb_x   = a_limb[idx_i];
        limb_y   = (op_q == OP_SQUARE) ? a_limb[idx_j] : b_limb[idx_j];
        dbl      = (op_q == OP_SQUARE) && (idx_i != idx_j);
        off_limb = OFF_W'(idx_i) + OFF_W'(idx_j);
    end

    bigmul_seq #(
        .NUM_LIMBS(NUM_LIMBS)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(accept),
        .op    (op_q),
        .issue (issue),
        .idx_i (idx_i),
        .idx_j (idx_j),
        .busy  (busy),
        .done  (done)
    );

    bigmul_mac #(
        .LIMB_W   (LIMB_W),
        .NUM_LIMBS(NUM_LIMBS)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .issue   (issue),
        .limb_x  (limb_x),
        .limb_y  (limb_y),
        .dbl     (dbl),
        .off_limb(off_limb),
        .acc     (acc)
    );

    assign result   = acc[RES_W-1:0];
    assign acc_head = acc[ACC_W-1:RES_W];

endmodule

// File: rtl/bigmul_chk.sv
// Module bigmul_chk
// Protocol and arithmetic-range checks for bigmul_top, bound into it.
// Counts busy cycles itself so the latency window never needs a deep $past.
module bigmul_chk #(
    parameter int LIMB_W    = 64,
    parameter int NUM_LIMBS = 11,
    localparam int RES_W = 2 * NUM_LIMBS * LIMB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic              busy,
    input  logic              done,
    input  logic [RES_W-1:0]  result,
    input  logic [LIMB_W-1:0] acc_head
);

    localparam int GEN_CYC = NUM_LIMBS * NUM_LIMBS + 1;
    localparam int SQR_CYC = NUM_LIMBS * (NUM_LIMBS + 1) / 2 + 1;

    int   busy_cnt;
    logic mode_seen;

    // Count busy cycles since the last accepted start and remember its mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt  <= 0;
            mode_seen <= 1'b0;
        end else if (start && !busy) begin
            busy_cnt  <= 0;
            mode_seen <= mode;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    // R3: headroom limb never receives a carry
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        acc_head == '0);

    // R4: general-mode latency
    a_r4_general_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        done && !mode_seen |-> busy_cnt == GEN_CYC);

    // R5: square-mode latency
    a_r5_square_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_seen |-> busy_cnt == SQR_CYC);

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done never overlaps busy
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: busy ends only when done rises
    a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: idle with no request keeps the result unchanged
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(result));

endmodule

bind bigmul_top bigmul_chk #(
    .LIMB_W   (LIMB_W),
    .NUM_LIMBS(NUM_LIMBS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .acc_head(acc_head)
);

// File: tb/bigmul_top_bench.sv
// Bench for bigmul_top on a 2-limb, 4-bit configuration: every A value in
// square mode, and every A against sixteen B values in general mode.
module bigmul_top_bench;

    localparam int LW   = 4;
    localparam int NL   = 2;
    localparam int OPW  = NL * LW;
    localparam int RW   = 2 * OPW;
    localparam int PGEN = NL * NL;
    localparam int PSQR = NL * (NL + 1) / 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           mode = 1'b0;
    logic [OPW-1:0] op_a = '0;
    logic [OPW-1:0] op_b = '0;
    logic           busy;
    logic           done;
    logic [RW-1:0]  result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bigmul_top #(
        .LIMB_W   (LW),
        .NUM_LIMBS(NL)
    ) u_bigmul_top (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mode  (mode),
        .op_a  (op_a),
        .op_b  (op_b),
        .busy  (busy),
        .done  (done),
        .result(result)
    );

    task automatic check(input string req, input logic [RW-1:0] got,
                         input logic [RW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // One operation; poke=1 fires a second start while busy (R7)
    task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                          input logic sq, input logic poke);
        logic [RW-1:0] exp;
        int            p;
        exp = sq ? RW'(a) * RW'(a) : RW'(a) * RW'(b);
        p   = sq ? PSQR : PGEN;
        @(negedge clk);
        op_a = a; op_b = b; mode = sq; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 busy after accept", RW'(busy), RW'(1));
        for (int k = 1; k <= p; k++) begin
            if (poke && k == 1) begin
                op_a = ~a; op_b = b + 1'b1; mode = ~sq; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(sq ? "R5 done not early" : "R4 done not early", RW'(done), RW'(0));
        @(negedge clk);
        check(sq ? "R5 done on time" : "R4 done on time", RW'(done), RW'(1));
        check("R6 busy low at done", RW'(busy), RW'(0));
        check(poke ? "R7 start ignored" : (sq ? "R2 square" : "R1 product"),
              result, exp);
        @(negedge clk);
        check("R6 done single cycle", RW'(done), RW'(0));
        @(negedge clk);
        @(negedge clk);
        check("R8 result held", result, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset busy", RW'(busy), RW'(0));
        check("R9 reset done", RW'(done), RW'(0));
        check("R9 reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: all-ones extremes in both modes
        run_op('1, '1, 1'b0, 1'b0);
        run_op('1, '1, 1'b1, 1'b0);
        run_op('1, '0, 1'b1, 1'b0);

        // R2: every A squared, with B varied to show it has no effect
        for (int a = 0; a < (1 << OPW); a++) begin
            run_op(OPW'(a), OPW'(~a * 7), 1'b1, 1'b0);
        end

        // R1: every A against sixteen spread B values
        for (int a = 0; a < (1 << OPW); a++) begin
            for (int bi = 0; bi < 16; bi++) begin
                run_op(OPW'(a), OPW'(bi * 17), 1'b0, 1'b0);
            end
        end

        // R7: start during busy in both modes
        run_op(8'hA7, 8'h3C, 1'b0, 1'b1);
        run_op(8'hE9, 8'h11, 1'b1, 1'b1);
        run_op(8'hFF, 8'hFE, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule